// File: doc/BRIEF.md
# Serial Command Frame Builder with Programmable CRC

This block assembles one outgoing command frame for a channel of a serial sensor bus. A frame is a short data word of configurable length (8 to 15 bits), followed by a CRC of configurable length (0 to 8 bits). The CRC's generator polynomial and starting seed are also configurable. The frame leaves one bit at a time: one bit per pulse on a bit-strobe input supplied by the bus timing logic, which lies outside this block.

Configuration enters through a plain register-write port. Out-of-range lengths are corrected in hardware when written. A data word is handed over with a valid/ready handshake. `in_ready` is high only while no frame is in flight, and a word is taken on any cycle where `in_valid` and `in_ready` are both high. A source that sees `in_ready` low must hold its word until the transfer completes. Each accepted word freezes a copy of the configuration, so writes made during a frame apply from the next frame on. The CRC length chosen here is the one a companion receive checker uses on data read back.

Top module: `cmd_framer`

## Requirements
- R1: After reset the word length is 8, the CRC length is 4, the polynomial is 0x07 and the seed is 0x00; `in_ready` is 1 and `tx_active` and `done` are 0.
- R2: Writing the word length (`cfg_addr`=0, `cfg_wdata[3:0]`) with a value below 8 stores the value with its bit 3 forced to 1, giving 8 to 15. Values from 8 to 15 are stored unchanged.
- R3: Writing the CRC length (`cfg_addr`=1, `cfg_wdata[3:0]`) with a value above 8 stores 8. Values 0 to 8 are stored unchanged.
- R4: With a CRC length of 0 the frame is the data word alone, and no CRC bits follow.
- R5: Polynomial (`cfg_addr`=2) and seed (`cfg_addr`=3) bits at positions equal to or above the CRC length have no effect on the frame.
- R6: With CRC length L, the CRC register starts at the masked seed. For each data bit b, taken MSB first, the block forms f = b XOR crc[L-1], shifts crc left by one within L bits, and XORs in the masked polynomial when f is 1.
- R7: The frame is data bits W-1 down to 0 (W = word length), then CRC bits L-1 down to 0. `tx_bit` presents the current bit, holds it steady between strobes, and moves to the next bit on each cycle with `bit_stb` high. `in_data` bits at W and above are not sent.
- R8: `done` is a one-cycle pulse in the cycle after the strobe of the last frame bit. `tx_active` falls in that same cycle.
- R9: `in_ready` is low while a frame is active. While `in_ready` is low, `in_valid` and `in_data` have no effect. An accepted word raises `tx_active` in the next cycle.
- R10: A configuration write made while a frame is active does not change that frame and takes effect from the next accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | 0 word length, 1 CRC length, 2 polynomial, 3 seed |
| cfg_wdata | input | 8 | Configuration write data |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Block can take a word (idle) |
| in_data | input | 15 | Data word, right-aligned |
| bit_stb | input | 1 | Advance to next frame bit |
| tx_bit | output | 1 | Current frame bit |
| tx_active | output | 1 | Frame in flight |
| done | output | 1 | One-cycle pulse after the last bit |

## Verification
The hardest situation to reach is a configuration write landing between two strobes in the middle of a frame, because only a frame that is partly sent can show that the snapshot held. The bench pauses its strobe sequence after three bits, issues a length write, and finishes the frame. It then checks that the frame still has the old length and that the following frame uses the new one. Clamped lengths are observed only through the bit count of the resulting frames, so each clamp vector is paired with a frame.

// File: rtl/framer_pkg.sv
package framer_pkg;
  typedef enum logic [1:0] {
    CFG_WLEN = 2'd0,
    CFG_CLEN = 2'd1,
    CFG_POLY = 2'd2,
    CFG_SEED = 2'd3
  } cfg_addr_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_CRC  = 2'd2
  } phase_e;
endpackage

// File: rtl/framer_cfg.sv
module framer_cfg #(
  parameter int LEN_W    = 4,
  parameter int CRC_W    = 8,
  parameter int WLEN_RST = 8,
  parameter int CLEN_RST = 4,
  parameter logic [CRC_W-1:0] POLY_RST = 8'h07,
  parameter logic [CRC_W-1:0] SEED_RST = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [CRC_W-1:0] wdata,
  output logic [LEN_W-1:0] wlen,
  output logic [LEN_W-1:0] clen,
  output logic [CRC_W-1:0] poly,
  output logic [CRC_W-1:0] seed
);
  import framer_pkg::*;

  localparam logic [LEN_W-1:0] WLEN_FLOOR = {1'b1, {(LEN_W-1){1'b0}}};
  localparam logic [LEN_W-1:0] CLEN_MAX   = LEN_W'(CRC_W);

  logic [LEN_W-1:0] len_field;
  assign len_field = wdata[LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wlen <= LEN_W'(WLEN_RST);
      clen <= LEN_W'(CLEN_RST);
      poly <= POLY_RST;
      seed <= SEED_RST;
    end else if (we) begin
      unique case (cfg_addr_e'(addr))
        CFG_WLEN: wlen <= len_field | WLEN_FLOOR;
        CFG_CLEN: clen <= (len_field > CLEN_MAX) ? CLEN_MAX : len_field;
        CFG_POLY: poly <= wdata;
        CFG_SEED: seed <= wdata;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/framer_crc_step.sv
module framer_crc_step #(
  parameter int LEN_W = 4,
  parameter int CRC_W = 8
) (
  input  logic [CRC_W-1:0] crc_in,
  input  logic [CRC_W-1:0] poly,
  input  logic [CRC_W-1:0] mask,
  input  logic [LEN_W-1:0] clen,
  input  logic             din,
  output logic [CRC_W-1:0] crc_out
);
  logic [CRC_W-1:0] top_sel;
  logic             fb;

  always_comb begin
    top_sel = '0;
    if (clen != '0) top_sel = CRC_W'(1) << (clen - LEN_W'(1));
    fb      = din ^ (|(crc_in & top_sel));
    crc_out = ((crc_in << 1) & mask) ^ (fb ? poly : '0);
  end
endmodule

// File: rtl/cmd_framer.sv
module cmd_framer #(
  parameter int LEN_W = 4,
  parameter int CRC_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_addr,
  input  logic [CRC_W-1:0]      cfg_wdata,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [(2**LEN_W)-2:0] in_data,
  input  logic                  bit_stb,
  output logic                  tx_bit,
  output logic                  tx_active,
  output logic                  done
);
  import framer_pkg::*;

  localparam int DATA_W = (2**LEN_W) - 1;

  logic [LEN_W-1:0] cfg_wlen, cfg_clen;
  logic [CRC_W-1:0] cfg_poly, cfg_seed;

  framer_cfg #(.LEN_W(LEN_W), .CRC_W(CRC_W)) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .wlen(cfg_wlen), .clen(cfg_clen), .poly(cfg_poly), .seed(cfg_seed)
  );

  phase_e           ph_q;
  logic [DATA_W-1:0] dsh_q;
  logic [CRC_W-1:0] crc_q, poly_q, mask_q;
  logic [LEN_W-1:0] clen_q, cnt_q;
  logic             done_q;

  logic [CRC_W:0]   mask_wide;
  logic [CRC_W-1:0] mask_new, crc_next;
  logic [LEN_W-1:0] data_align, crc_align;
  logic             accept;

  assign mask_wide  = ({{CRC_W{1'b0}}, 1'b1} << cfg_clen) - 1'b1;
  assign mask_new   = mask_wide[CRC_W-1:0];
  assign data_align = LEN_W'(DATA_W) - cfg_wlen;
  assign crc_align  = LEN_W'(CRC_W) - clen_q;
  assign accept     = in_valid && in_ready;

  framer_crc_step #(.LEN_W(LEN_W), .CRC_W(CRC_W)) step_i (
    .crc_in(crc_q), .poly(poly_q), .mask(mask_q), .clen(clen_q),
    .din(dsh_q[DATA_W-1]), .crc_out(crc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      dsh_q  <= '0;
      crc_q  <= '0;
      poly_q <= '0;
      mask_q <= '0;
      clen_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (accept) begin
          dsh_q  <= in_data << data_align;
          crc_q  <= cfg_seed & mask_new;
          poly_q <= cfg_poly & mask_new;
          mask_q <= mask_new;
          clen_q <= cfg_clen;
          cnt_q  <= cfg_wlen;
          ph_q   <= PH_DATA;
        end
        PH_DATA: if (bit_stb) begin
          dsh_q <= dsh_q << 1;
          cnt_q <= cnt_q - LEN_W'(1);
          crc_q <= crc_next;
          if (cnt_q == LEN_W'(1)) begin
            if (clen_q == '0) begin
              ph_q   <= PH_IDLE;
              done_q <= 1'b1;
            end else begin
              ph_q  <= PH_CRC;
              cnt_q <= clen_q;
              crc_q <= crc_next << crc_align;
            end
          end
        end
        PH_CRC: if (bit_stb) begin
          crc_q <= crc_q << 1;
          cnt_q <= cnt_q - LEN_W'(1);
          if (cnt_q == LEN_W'(1)) begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign in_ready  = (ph_q == PH_IDLE);
  assign tx_active = (ph_q != PH_IDLE);
  assign tx_bit    = (ph_q == PH_DATA) ? dsh_q[DATA_W-1] :
                     (ph_q == PH_CRC)  ? crc_q[CRC_W-1]  : 1'b0;
  assign done      = done_q;
endmodule

// File: rtl/framer_chk.sv
module framer_chk #(
  parameter int LEN_W = 4,
  parameter int CRC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             bit_stb,
  input logic             tx_bit,
  input logic             tx_active,
  input logic             done,
  input logic [LEN_W-1:0] cfg_wlen,
  input logic [LEN_W-1:0] cfg_clen
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !tx_active);
  a_r8_end_marked: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_active) |-> done);
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    tx_active |-> !in_ready);
  a_r9_accept_starts: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> tx_active);
  a_r7_bit_holds: assert property (@(posedge clk) disable iff (rst)
    (tx_active && $past(tx_active) && !$past(bit_stb)) |-> $stable(tx_bit));
  a_r2_wlen_floor: assert property (@(posedge clk) disable iff (rst)
    cfg_wlen[LEN_W-1]);
  a_r3_clen_ceiling: assert property (@(posedge clk) disable iff (rst)
    cfg_clen <= LEN_W'(CRC_W));
endmodule

bind cmd_framer framer_chk #(.LEN_W(LEN_W), .CRC_W(CRC_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .bit_stb(bit_stb), .tx_bit(tx_bit), .tx_active(tx_active), .done(done),
  .cfg_wlen(cfg_wlen), .cfg_clen(cfg_clen)
);

// File: tb/cmd_framer_tb.sv
module cmd_framer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [14:0] in_data = '0;
  logic bit_stb = 1'b0;
  logic tx_bit, tx_active, done;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  cmd_framer dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .bit_stb(bit_stb), .tx_bit(tx_bit),
    .tx_active(tx_active), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL R8 watchdog: actual=%0d cycles expected<100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int model(input int wl, input int cl, input logic [7:0] poly,
                               input logic [7:0] seed, input logic [14:0] d);
    int mask = (1 << cl) - 1;
    int c = int'(seed) & mask;
    int p = int'(poly) & mask;
    for (int i = wl - 1; i >= 0; i--) begin
      if (cl > 0) begin
        int fb = int'(d[i]) ^ ((c >> (cl - 1)) & 1);
        c = ((c << 1) & mask) ^ (fb != 0 ? p : 0);
      end
    end
    return ((int'(d) & ((1 << wl) - 1)) << cl) | c;
  endfunction

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] v);
    cfg_addr = a; cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Sends one word and checks length, bits, and the done pulse.
  // mid: write word length 12 after three bits (R10).
  task automatic send_frame(input logic [14:0] d, input int exp_n, input int exp_v,
                            input string tag, input bit mid);
    int n = 0;
    int got = 0;
    in_data = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    while (n < 40) begin
      got = (got << 1) | int'(tx_bit);
      n++;
      bit_stb = 1'b1;
      @(negedge clk);
      bit_stb = 1'b0;
      if (done) break;
      if (mid && n == 3) begin
        in_valid = 1'b1; in_data = 15'h7FFF;
        check(in_ready == 1'b0, "R9 ready low mid-frame", int'(in_ready), 0);
        cfg_write(2'd0, 8'd12);
        in_valid = 1'b0;
      end
      if (n % 4 == 1) @(negedge clk);
    end
    check(n == exp_n, {tag, " R7 frame length"}, n, exp_n);
    check(got == exp_v, {tag, " R6/R7 frame bits"}, got, exp_v);
    check(done && !tx_active, {tag, " R8 done with tx_active low"}, int'({done, tx_active}), 2);
    @(negedge clk);
    check(!done, {tag, " R8 done one cycle"}, int'(done), 0);
  endtask

  // {wlen write, clen write, poly, seed, data}
  localparam int NV = 7;
  localparam logic [38:0] VEC [NV] = '{
    {4'd9,  4'd5,  8'h15, 8'h1F, 15'h01A5},
    {4'd3,  4'd6,  8'h2F, 8'h00, 15'h05B3},
    {4'd0,  4'd12, 8'h07, 8'hFF, 15'h00C3},
    {4'd15, 4'd0,  8'hFF, 8'hFF, 15'h7ABC},
    {4'd10, 4'd3,  8'hFB, 8'hFE, 15'h02D6},
    {4'd12, 4'd15, 8'h9B, 8'h81, 15'h7FFF},
    {4'd7,  4'd1,  8'h01, 8'h00, 15'h1234}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(in_ready && !tx_active && !done, "R1 idle after reset",
          int'({in_ready, tx_active, done}), 4);
    // R1 defaults: wlen 8, clen 4, poly 0x07, seed 0x00
    send_frame(15'h00A5, 12, model(8, 4, 8'h07, 8'h00, 15'h00A5), "R1 defaults", 1'b0);

    // R9: no word offered, no frame starts
    repeat (3) @(negedge clk);
    check(!tx_active, "R9 idle without in_valid", int'(tx_active), 0);

    for (int v = 0; v < NV; v++) begin
      logic [38:0] e = VEC[v];
      int wl = int'(e[38:35]) | 8;                          // R2 clamp
      int cl = (int'(e[34:31]) > 8) ? 8 : int'(e[34:31]);   // R3 clamp
      cfg_write(2'd0, {4'd0, e[38:35]});
      cfg_write(2'd1, {4'd0, e[34:31]});
      cfg_write(2'd2, e[30:23]);
      cfg_write(2'd3, e[22:15]);
      // R2 R3 R4 R5 exercised by the table rows
      send_frame(e[14:0], wl + cl, model(wl, cl, e[30:23], e[22:15], e[14:0]),
                 $sformatf("R2/R3/R4/R5 vec%0d", v), 1'b0);
    end

    // R5 directly: poly 0x03 matches poly 0xFB under clen 3, same seed low bits
    cfg_write(2'd0, 8'd10); cfg_write(2'd1, 8'd3);
    cfg_write(2'd2, 8'h03); cfg_write(2'd3, 8'h06);
    send_frame(15'h02D6, 13, model(10, 3, 8'hFB, 8'hFE, 15'h02D6), "R5 masked bits", 1'b0);

    // R10: mid-frame write of word length 12 keeps this frame at 8 bits
    cfg_write(2'd0, 8'd8); cfg_write(2'd1, 8'd4);
    cfg_write(2'd2, 8'h07); cfg_write(2'd3, 8'h00);
    send_frame(15'h0F0F, 12, model(8, 4, 8'h07, 8'h00, 15'h0F0F), "R10 current frame", 1'b1);
    send_frame(15'h0F0F, 16, model(12, 4, 8'h07, 8'h00, 15'h0F0F), "R10 next frame", 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule